// File: doc/BRIEF.md
# Masked Interrupt Collector with Halt Wake

This block gathers up to thirty-two single-cycle interrupt request pulses into one level-sensitive interrupt line for a CPU. Each pulse latches a sticky flag bit. Software reaches the block through a small 16-bit register bus. It can turn the whole line on or off with a master switch, select which flags may reach the CPU through a 32-bit mask, and acknowledge a flag by writing a one to its bit. Any change to the switch or the mask re-evaluates the flags that are already pending, so a stale request reaches the CPU as soon as it is unmasked.

The block also tracks whether the CPU is halted. A halt strobe from the CPU sets the halted state. Any incoming request clears it and produces a one-cycle wake pulse, whatever the master switch or the mask say. A 32-bit bus write is split into a low halfword at the given address and a high halfword at the next address, both applied in the same cycle. A 32-bit write to the low mask address therefore loads the whole mask at once.

Register map by halfword address: 0 master switch, 1 mask bits 0–15, 2 mask bits 16–31, 3 flag bits 0–15, 4 flag bits 16–31. Addresses 5–7 are unmapped.

Top module: `irq_collector`

## Requirements
- R1: After reset every register reads zero, and `irq_out`, `cpu_halted` and `wake` are low.
- R2: A pulse on `src_req[i]` sets flag bit i at the next clock edge. Bits 0–15 read back at address 3 and bits 16–31 at address 4, each in bit position i mod 16.
- R3: Writing a halfword to address 3 or 4 clears each flag bit written as 1 and leaves each bit written as 0. A request arriving in the same cycle as its clear wins, and the bit stays set.
- R4: `irq_out` is a registered level. In each cycle it equals (master != 0) AND ((mask AND flag) != 0), computed from the register values of the previous cycle. It therefore drops one cycle after the last enabled flag is cleared or the master switch is zeroed.
- R5: Writing a non-zero master value while an enabled flag is pending raises `irq_out` one cycle after the write takes effect.
- R6: Writing the mask so that it uncovers a pending flag raises `irq_out` one cycle after the write takes effect, provided the master switch is non-zero. A flag that stays masked never raises `irq_out`.
- R7: The master switch (address 0) and both mask halves (addresses 1 and 2) read back exactly what was last written.
- R8: A 32-bit write (`reg_wide`=1) applies `reg_wdata[15:0]` to `reg_addr` and `reg_wdata[31:16]` to `reg_addr`+1 in the same cycle. At address 1 this loads the full mask, and at address 3 it clears flags in both halves.
- R9: `halt_strobe` sets `cpu_halted` at the next edge. Any request clears it at the next edge, regardless of the master switch and mask. A strobe and a request in the same cycle leave it cleared.
- R10: `wake` is high in exactly the cycle that follows each cycle with at least one request, and low otherwise.
- R11: Addresses 5–7 read zero and writes to them change nothing. This includes the high half of a 32-bit write at address 4 and the high half of a 32-bit write at address 7, which has no next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Single-cycle request pulse per source |
| halt_strobe | input | 1 | CPU entering halt |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | Write is 32 bits (two halfwords) |
| reg_addr | input | 3 | Halfword register address |
| reg_wdata | input | 32 | Write data; the upper half is used only when `reg_wide` is set |
| reg_rdata | output | 16 | Combinational read of `reg_addr` |
| irq_out | output | 1 | Level interrupt to the CPU |
| cpu_halted | output | 1 | CPU halted state |
| wake | output | 1 | One-cycle wake pulse |

## Verification
Two pairs of functions can land in the same cycle. A flag acknowledge can meet a new request for the same bit, and a halt strobe can meet a request. The bench drives each pair in a single cycle and checks at the port level that the request wins: the flag reads back set and `cpu_halted` reads low. A sweep over all 32 sources checks latching, wake, masking and acknowledge per bit. The expected interrupt level is computed from the registers the bench has written, one cycle behind them.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

    localparam int HALF_W = 16;
    localparam int ADDR_W = 3;
    localparam int NSRC   = 2 * HALF_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASTER  = 3'd0,
        RA_MASK_LO = 3'd1,
        RA_MASK_HI = 3'd2,
        RA_FLAG_LO = 3'd3,
        RA_FLAG_HI = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] data;
    } half_wr_t;

    function automatic logic half_hits(half_wr_t w, reg_sel_e sel);
        return w.en && (w.addr == sel);
    endfunction

    function automatic logic [HALF_W-1:0] half_data_for(half_wr_t w, reg_sel_e sel);
        return half_hits(w, sel) ? w.data : '0;
    endfunction

endpackage

// File: rtl/irq_bus_split.sv
module irq_bus_split
    import irq_collector_pkg::*;
(
    input  logic                  wr,
    input  logic                  wide,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*HALF_W-1:0]   wdata,
    output half_wr_t              lo_wr,
    output half_wr_t              hi_wr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    always_comb begin
        lo_wr.en   = wr;
        lo_wr.addr = addr;
        lo_wr.data = wdata[HALF_W-1:0];
        // upper half goes to the next halfword; none exists past the top
        hi_wr.en   = wr && wide && (addr != LAST_ADDR);
        hi_wr.addr = addr + ADDR_W'(1);
        hi_wr.data = wdata[2*HALF_W-1:HALF_W];
    end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_collector_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  half_wr_t          lo_wr,
    input  half_wr_t          hi_wr,
    output logic [HALF_W-1:0] master,
    output logic [NSRC-1:0]   mask
);
    always_ff @(posedge clk) begin
        if (rst)                          master <= '0;
        else if (half_hits(lo_wr, RA_MASTER)) master <= lo_wr.data;
    end

    for (genvar h = 0; h < 2; h++) begin : g_mask_half
        localparam reg_sel_e SEL = (h == 0) ? RA_MASK_LO : RA_MASK_HI;
        always_ff @(posedge clk) begin
            if (rst)
                mask[h*HALF_W +: HALF_W] <= '0;
            else if (half_hits(hi_wr, SEL))
                mask[h*HALF_W +: HALF_W] <= hi_wr.data;
            else if (half_hits(lo_wr, SEL))
                mask[h*HALF_W +: HALF_W] <= lo_wr.data;
        end
    end

    a_r7_master_holds: assert property (@(posedge clk) disable iff (rst)
        !half_hits(lo_wr, RA_MASTER) |=> $stable(master));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_collector_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  half_wr_t        lo_wr,
    input  half_wr_t        hi_wr,
    output logic [NSRC-1:0] flag
);
    logic [NSRC-1:0] clr;

    for (genvar h = 0; h < 2; h++) begin : g_flag_half
        localparam reg_sel_e SEL = (h == 0) ? RA_FLAG_LO : RA_FLAG_HI;
        assign clr[h*HALF_W +: HALF_W] = half_data_for(lo_wr, SEL) | half_data_for(hi_wr, SEL);
        always_ff @(posedge clk) begin
            if (rst)
                flag[h*HALF_W +: HALF_W] <= '0;
            else
                flag[h*HALF_W +: HALF_W] <= (flag[h*HALF_W +: HALF_W] & ~clr[h*HALF_W +: HALF_W])
                                          | src_req[h*HALF_W +: HALF_W];
        end
    end

    a_r2_req_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (src_req != '0) |=> ((flag & $past(src_req)) == $past(src_req)));

    a_r3_change_has_cause: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flag ^ $past(flag)) & ~$past(src_req) & ~$past(clr)) == '0));
endmodule

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl
    import irq_collector_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_req,
    input  logic            halt_strobe,
    output logic            cpu_halted,
    output logic            wake
);
    logic any_req;
    assign any_req = |src_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_halted <= 1'b0;
            wake       <= 1'b0;
        end else begin
            wake <= any_req;
            if (any_req)          cpu_halted <= 1'b0;
            else if (halt_strobe) cpu_halted <= 1'b1;
        end
    end

    a_r9_req_releases_halt: assert property (@(posedge clk) disable iff (rst)
        any_req |=> !cpu_halted);
    a_r9_strobe_halts: assert property (@(posedge clk) disable iff (rst)
        (halt_strobe && !any_req) |=> cpu_halted);
    a_r10_wake_follows_req: assert property (@(posedge clk) disable iff (rst)
        any_req |=> wake);
    a_r10_no_spurious_wake: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> !wake);
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_collector_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         src_req,
    input  logic                halt_strobe,
    input  logic                reg_wr,
    input  logic                reg_wide,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic                irq_out,
    output logic                cpu_halted,
    output logic                wake
);
    half_wr_t          lo_wr, hi_wr;
    logic [HALF_W-1:0] master;
    logic [NSRC-1:0]   mask;
    logic [NSRC-1:0]   flag;

    irq_bus_split u_split (
        .wr(reg_wr), .wide(reg_wide), .addr(reg_addr), .wdata(reg_wdata),
        .lo_wr(lo_wr), .hi_wr(hi_wr)
    );

    irq_ctl_regs u_ctl (
        .clk(clk), .rst(rst), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .master(master), .mask(mask)
    );

    irq_flag_bank u_flags (
        .clk(clk), .rst(rst), .src_req(src_req), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .flag(flag)
    );

    irq_wake_ctl u_wake (
        .clk(clk), .rst(rst), .src_req(src_req), .halt_strobe(halt_strobe),
        .cpu_halted(cpu_halted), .wake(wake)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= (master != '0) && ((mask & flag) != '0);
    end

    always_comb begin
        case (reg_addr)
            RA_MASTER:  reg_rdata = master;
            RA_MASK_LO: reg_rdata = mask[HALF_W-1:0];
            RA_MASK_HI: reg_rdata = mask[NSRC-1:HALF_W];
            RA_FLAG_LO: reg_rdata = flag[HALF_W-1:0];
            RA_FLAG_HI: reg_rdata = flag[NSRC-1:HALF_W];
            default:    reg_rdata = '0;
        endcase
    end

    a_r4_irq_tracks_state: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == (($past(master) != '0) && (($past(mask) & $past(flag)) != '0))));
    a_r6_masked_stays_quiet: assert property (@(posedge clk) disable iff (rst)
        ((mask & flag) == '0) |=> !irq_out);
endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic        halt_strobe = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_wide = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out, cpu_halted, wake;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_collector i_irq_collector (
        .clk(clk), .rst(rst), .src_req(src_req), .halt_strobe(halt_strobe),
        .reg_wr(reg_wr), .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .cpu_halted(cpu_halted), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic w);
        reg_wr = 1'b1; reg_wide = w; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wide = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] m);
        src_req = m;
        step();
        src_req = '0;
    endtask

    task automatic flags(output logic [31:0] f);
        logic [15:0] l, h;
        rd(3'd3, l);
        rd(3'd4, h);
        f = {h, l};
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] f;
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg after reset", {16'h0, d}, 32'h0);
        end
        chk("R1 outputs after reset", {29'h0, irq_out, cpu_halted, wake}, 32'h0);

        // R7 readback
        wr(3'd0, 32'h0000_8001, 1'b0);
        wr(3'd1, 32'h0000_A5A5, 1'b0);
        wr(3'd2, 32'h0000_5A5A, 1'b0);
        rd(3'd0, d); chk("R7 master readback", {16'h0, d}, 32'h8001);
        rd(3'd1, d); chk("R7 mask lo readback", {16'h0, d}, 32'hA5A5);
        rd(3'd2, d); chk("R7 mask hi readback", {16'h0, d}, 32'h5A5A);

        // R11 unmapped addresses
        wr(3'd5, 32'h0000_FFFF, 1'b0);
        wr(3'd7, 32'hFFFF_FFFF, 1'b1);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            chk("R11 unmapped reads zero", {16'h0, d}, 32'h0);
        end
        rd(3'd0, d); chk("R11 wide at top leaves master", {16'h0, d}, 32'h8001);

        // R8 wide writes
        wr(3'd1, 32'h1234_ABCD, 1'b1);
        rd(3'd1, d); chk("R8 wide mask lo", {16'h0, d}, 32'hABCD);
        rd(3'd2, d); chk("R8 wide mask hi", {16'h0, d}, 32'h1234);
        wr(3'd0, 32'h0F0F_0000, 1'b1);
        rd(3'd0, d); chk("R8 wide at 0 master", {16'h0, d}, 32'h0);
        rd(3'd1, d); chk("R8 wide at 0 spills into mask lo", {16'h0, d}, 32'h0F0F);
        wr(3'd1, 32'h0, 1'b1);
        step();

        // R2 / R3 / R10 sweep of all sources
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            chk("R10 wake after request", {31'h0, wake}, 32'h1);
            flags(f);
            chk("R2 flag latched", f, 32'h1 << i);
            wr((i < 16) ? 3'd3 : 3'd4, 32'h0, 1'b0);
            chk("R10 wake single cycle", {31'h0, wake}, 32'h0);
            flags(f);
            chk("R3 zero write keeps flag", f, 32'h1 << i);
            wr((i < 16) ? 3'd3 : 3'd4, 32'(16'h1 << (i % 16)), 1'b0);
            flags(f);
            chk("R3 one write clears flag", f, 32'h0);
        end

        // R4 / R5 / R6 sweep
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            wr(3'd1, ~(32'h1 << i), 1'b1);
            wr(3'd0, 32'h1, 1'b0);
            step();
            chk("R6 masked flag gives no irq", {31'h0, irq_out}, 32'h0);
            wr(3'd1, 32'h1 << i, 1'b1);
            chk("R4 irq lags mask write", {31'h0, irq_out}, 32'h0);
            step();
            chk("R6 uncovering mask raises irq", {31'h0, irq_out}, 32'h1);
            wr((i < 16) ? 3'd3 : 3'd4, 32'(16'h1 << (i % 16)), 1'b0);
            chk("R4 irq still high at clear edge", {31'h0, irq_out}, 32'h1);
            step();
            chk("R4 irq drops after clear", {31'h0, irq_out}, 32'h0);
            wr(3'd0, 32'h0, 1'b0);
        end

        // R5 master switch
        wr(3'd1, 32'h0000_0010, 1'b1);
        pulse(32'h10);
        step();
        chk("R5 master off no irq", {31'h0, irq_out}, 32'h0);
        wr(3'd0, 32'h4000, 1'b0);
        step();
        chk("R5 master on raises irq", {31'h0, irq_out}, 32'h1);
        wr(3'd0, 32'h0, 1'b0);
        step();
        chk("R4 master off drops irq", {31'h0, irq_out}, 32'h0);
        wr(3'd3, 32'h10, 1'b0);

        // R3 request beats same-cycle clear
        pulse(32'h80);
        src_req = 32'h80;
        wr(3'd3, 32'h0180, 1'b0);
        src_req = '0;
        flags(f);
        chk("R3 request wins over clear", f, 32'h80);
        pulse(32'h0001_0000);
        wr(3'd3, 32'h0001_0080, 1'b1);
        flags(f);
        chk("R8 wide clear both halves", f, 32'h0);

        // R9 halt / wake
        halt_strobe = 1'b1; step(); halt_strobe = 1'b0;
        chk("R9 strobe halts", {31'h0, cpu_halted}, 32'h1);
        step(); step();
        chk("R9 halt holds", {31'h0, cpu_halted}, 32'h1);
        pulse(32'h20);
        chk("R9 masked request wakes", {31'h0, cpu_halted}, 32'h0);
        chk("R10 wake with master off", {31'h0, wake}, 32'h1);
        wr(3'd3, 32'h20, 1'b0);
        halt_strobe = 1'b1; src_req = 32'h8000_0000;
        step();
        halt_strobe = 1'b0; src_req = '0;
        chk("R9 simultaneous resolves clear", {31'h0, cpu_halted}, 32'h0);
        src_req = 32'h3; step(); src_req = 32'h4; step(); src_req = '0;
        chk("R10 wake on back-to-back", {31'h0, wake}, 32'h1);
        step();
        chk("R10 wake ends", {31'h0, wake}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule